// File: doc/BRIEF.md
# Parallel Disk Command Handshake Responder

This block is the device-side front end of a legacy parallel hard-disk link. The host signals a request on an active-low command strobe and sets a direction line (high means read, low means write). The block answers on an active-low busy line and tells a downstream transfer engine when to start or when to abandon the transaction. Both host lines are sampled through a two-flop synchronizer. The strobe then passes through a glitch filter, so only a low level that holds long enough starts a transaction.

The block checks the order in which the host moves its lines. A valid write lowers the direction line no later than the release of the strobe. If the strobe is released while the direction line is still high, the block waits a programmable grace interval for the line to fall. If it does not fall in that time, the block abandons the transaction. A grace of zero abandons at once. A watchdog puts a hard upper bound on how long busy can stay low. The bursts of strobe wiggles that a host sends while it initialises therefore always leave busy released within a bounded time. A debug port shows the current state code and a saturating count of abandoned transactions.

Top module: `pcr_responder`

## Requirements
- R1: After reset, busy is high (released), both pulse outputs are low, the state code is 0 and the abort count is 0.
- R2: A strobe low level that holds for fewer than FILT_LEN clocks is ignored. A low level that holds for FILT_LEN clocks drives busy low exactly FILT_LEN+2 clocks after the pin changes. This count includes the two synchronizer stages.
- R3: If the direction line is low when the synchronized strobe release is seen, the block issues exactly one start pulse. Busy is high in the cycle that pulse is visible, and no abort pulse is issued.
- R4: With a grace of 0, a release seen while the direction line is high gives exactly one abort pulse and no start pulse, and busy is released.
- R5: With grace G > 0, a direction fall that arrives d clocks after the release (1 ≤ d ≤ G) is accepted as in R3. If d > G, or the line never falls, the block enters the grace state (code 3) and issues an abort pulse G clocks after entering it.
- R6: Busy never stays low for more than WDOG_LIMIT consecutive clocks. When that limit is reached, an abort pulse is issued.
- R7: If an acceptance and the watchdog limit fall in the same cycle, the watchdog wins: the block issues an abort pulse and no start pulse.
- R8: After an abort, a strobe that is still held low starts nothing. A new command needs the strobe to go high and then low again for FILT_LEN clocks.
- R9: Start and abort pulses are each exactly one clock wide and never high together.
- R10: The state code reads 0 idle, 1 acknowledge, 2 wait-for-release, 3 grace, 4 abort. Busy is low exactly in codes 1 to 3.
- R11: The abort count rises by one on each abort pulse and saturates at 2^TALLY_W−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd_n_i | input | 1 | Host command strobe, active low, asynchronous |
| host_dir_i | input | 1 | Host direction, 1 read / 0 write, asynchronous |
| grace_cfg_i | input | GRACE_W | Grace interval in clocks, 0 for immediate abort |
| dev_busy_n_o | output | 1 | Busy reply to host, active low |
| xfer_start_o | output | 1 | One-clock pulse: transaction accepted |
| xfer_abort_o | output | 1 | One-clock pulse: transaction abandoned |
| dbg_state_o | output | 3 | Current state code |
| dbg_aborts_o | output | TALLY_W | Saturating count of abandoned transactions |

## Verification
Acceptance of a correctly ordered release and expiry of the watchdog can land in the same clock. The bench provokes this by counting busy-low clocks and then releasing the strobe, with the direction already low, so that the synchronized release reaches the state machine in the last allowed busy cycle. That run must give an abort pulse and no start pulse. The same release one clock earlier must give a start pulse and no abort, which shows that the watchdog bound is exact and not merely loose.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACK   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_GRACE = 3'd3,
    ST_ABORT = 3'd4
  } pcr_state_e;

  // Busy is held low only while a transaction is being worked on.
  function automatic logic holds_busy(input pcr_state_e s);
    return (s == ST_ACK) || (s == ST_WAIT) || (s == ST_GRACE);
  endfunction

  // True in the final grace cycle: cnt counts grace cycles already spent.
  function automatic logic grace_last(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction

  // Saturating increment, done on a 32-bit view; the caller narrows the result.
  function automatic logic [31:0] sat_inc(input logic [31:0] val, input logic [31:0] top);
    return (val >= top) ? top : val + 32'd1;
  endfunction

endpackage

// File: rtl/pcr_sync.sv
module pcr_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain <= {chain[STAGES-2:0], d_async};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pcr_strobe_filter.sv
module pcr_strobe_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_low,
  output logic cmd_fire
);

  localparam int CW = $clog2(FILT_LEN + 1);

  logic [CW-1:0] run_len;

  // Counts consecutive low clocks and saturates, so each held level fires once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (!cmd_low) begin
      run_len <= '0;
    end else if (run_len != CW'(FILT_LEN)) begin
      run_len <= run_len + 1'b1;
    end
  end

  assign cmd_fire = cmd_low && (run_len == CW'(FILT_LEN - 1));

endmodule

// File: rtl/pcr_ctrl_fsm.sv
module pcr_ctrl_fsm
  import pcr_pkg::*;
#(
  parameter int GRACE_W    = 8,
  parameter int WDOG_LIMIT = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_fire,
  input  logic               cmd_high,
  input  logic               dir_high,
  input  logic [GRACE_W-1:0] grace_cfg,
  output pcr_state_e         state,
  output logic               accept,
  output logic               wd_expire,
  output logic               grace_expire,
  output logic               start_pulse
);

  localparam int WW = $clog2(WDOG_LIMIT + 1);

  pcr_state_e       nxt;
  logic [WW-1:0]    wcnt;
  logic [GRACE_W-1:0] gcnt;
  logic             in_busy;
  logic             release_seen;
  logic             grace_zero;

  assign in_busy      = holds_busy(state);
  assign release_seen = (state == ST_WAIT) && cmd_high;
  assign grace_zero   = (grace_cfg == '0);
  assign wd_expire    = in_busy && (wcnt == WW'(WDOG_LIMIT - 1));
  assign grace_expire = (state == ST_GRACE) && dir_high &&
                        grace_last(32'(gcnt), 32'(grace_cfg));
  assign accept       = !wd_expire && !dir_high &&
                        (release_seen || (state == ST_GRACE));

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (cmd_fire) nxt = ST_ACK;
      ST_ACK:   nxt = ST_WAIT;
      ST_WAIT: begin
        if (cmd_high) begin
          if (!dir_high)       nxt = ST_IDLE;
          else if (grace_zero) nxt = ST_ABORT;
          else                 nxt = ST_GRACE;
        end
      end
      ST_GRACE: begin
        if (!dir_high)         nxt = ST_IDLE;
        else if (grace_expire) nxt = ST_ABORT;
      end
      ST_ABORT: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (wd_expire) nxt = ST_ABORT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      wcnt        <= '0;
      gcnt        <= '0;
      start_pulse <= 1'b0;
    end else begin
      state       <= nxt;
      start_pulse <= accept;
      wcnt        <= in_busy ? wcnt + 1'b1 : '0;
      gcnt        <= (state == ST_GRACE) ? gcnt + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/pcr_abort_tally.sv
module pcr_abort_tally
  import pcr_pkg::*;
#(
  parameter int TALLY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bump,
  output logic [TALLY_W-1:0] count
);

  localparam logic [31:0] TOP = 32'((64'd1 << TALLY_W) - 64'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (bump) begin
      count <= TALLY_W'(sat_inc(32'(count), TOP));
    end
  end

endmodule

// File: rtl/pcr_responder.sv
module pcr_responder
  import pcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int GRACE_W     = 8,
  parameter int WDOG_LIMIT  = 200,
  parameter int TALLY_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_cmd_n_i,
  input  logic               host_dir_i,
  input  logic [GRACE_W-1:0] grace_cfg_i,
  output logic               dev_busy_n_o,
  output logic               xfer_start_o,
  output logic               xfer_abort_o,
  output logic [2:0]         dbg_state_o,
  output logic [TALLY_W-1:0] dbg_aborts_o
);

  logic [1:0] sync_q;
  logic       cmd_s;
  logic       dir_s;

  // Named internal events, observed by the bound checker.
  logic       evt_fire;
  logic       evt_accept;
  logic       evt_wd_expire;
  logic       evt_grace_expire;
  pcr_state_e cur_state;

  pcr_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({host_cmd_n_i, host_dir_i}),
    .q      (sync_q)
  );

  assign cmd_s = sync_q[1];
  assign dir_s = sync_q[0];

  pcr_strobe_filter #(
    .FILT_LEN(FILT_LEN)
  ) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_low (!cmd_s),
    .cmd_fire(evt_fire)
  );

  pcr_ctrl_fsm #(
    .GRACE_W   (GRACE_W),
    .WDOG_LIMIT(WDOG_LIMIT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_fire    (evt_fire),
    .cmd_high    (cmd_s),
    .dir_high    (dir_s),
    .grace_cfg   (grace_cfg_i),
    .state       (cur_state),
    .accept      (evt_accept),
    .wd_expire   (evt_wd_expire),
    .grace_expire(evt_grace_expire),
    .start_pulse (xfer_start_o)
  );

  assign xfer_abort_o = (cur_state == ST_ABORT);
  assign dev_busy_n_o = !holds_busy(cur_state);
  assign dbg_state_o  = cur_state;

  pcr_abort_tally #(
    .TALLY_W(TALLY_W)
  ) u_tally (
    .clk  (clk),
    .rst_n(rst_n),
    .bump (xfer_abort_o),
    .count(dbg_aborts_o)
  );

endmodule

// File: rtl/pcr_responder_chk.sv
module pcr_responder_chk #(
  parameter int WDOG_LIMIT = 200,
  parameter int TALLY_W    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy_n,
  input logic               start_p,
  input logic               abort_p,
  input logic [2:0]         state,
  input logic [TALLY_W-1:0] tally,
  input logic               evt_fire,
  input logic               evt_accept,
  input logic               evt_wd_expire,
  input logic               evt_grace_expire
);

  localparam int RW = $clog2(WDOG_LIMIT + 2);

  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_run <= '0;
    else if (!busy_n) low_run <= low_run + 1'b1;
    else              low_run <= '0;
  end

  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> (low_run < RW'(WDOG_LIMIT)));

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_p && abort_p));

  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !start_p);

  a_r9_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |=> !abort_p);

  a_r2_ack_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1) |-> ($past(state) == 3'd0 && $past(evt_fire)));

  a_r3_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> (start_p && busy_n));

  a_r4_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |=> (state == 3'd0));

  a_r5_grace_expiry_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    evt_grace_expire |=> abort_p);

  a_r7_watchdog_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wd_expire |=> (abort_p && !start_p));

  a_r11_tally_step: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_p && tally != '1) |=> (tally == $past(tally) + 1'b1));

  a_r11_tally_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_p || tally == '1) |=> $stable(tally));

endmodule

bind pcr_responder pcr_responder_chk #(
  .WDOG_LIMIT(WDOG_LIMIT),
  .TALLY_W   (TALLY_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy_n          (dev_busy_n_o),
  .start_p         (xfer_start_o),
  .abort_p         (xfer_abort_o),
  .state           (dbg_state_o),
  .tally           (dbg_aborts_o),
  .evt_fire        (evt_fire),
  .evt_accept      (evt_accept),
  .evt_wd_expire   (evt_wd_expire),
  .evt_grace_expire(evt_grace_expire)
);

// File: tb/test_pcr_responder.sv
`timescale 1ns/1ps
module test_pcr_responder;

  localparam int FILT  = 4;
  localparam int GW    = 8;
  localparam int WDOG  = 200;
  localparam int TW    = 4;
  localparam int TMAX  = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_n = 1'b1;
  logic          dir = 1'b1;
  logic [GW-1:0] grace = '0;
  logic          busy_n;
  logic          start_p;
  logic          abort_p;
  logic [2:0]    st;
  logic [TW-1:0] aborts;

  int checks = 0;
  int failures = 0;
  int n_start = 0;
  int n_abort = 0;
  int exp_tally = 0;

  always #4 clk = ~clk;

  pcr_responder #(
    .SYNC_STAGES(2), .FILT_LEN(FILT), .GRACE_W(GW), .WDOG_LIMIT(WDOG), .TALLY_W(TW)
  ) i_pcr_responder (
    .clk(clk), .rst_n(rst_n), .host_cmd_n_i(cmd_n), .host_dir_i(dir),
    .grace_cfg_i(grace), .dev_busy_n_o(busy_n), .xfer_start_o(start_p),
    .xfer_abort_o(abort_p), .dbg_state_o(st), .dbg_aborts_o(aborts)
  );

  // Pulse-high cycles are counted, so a count of 1 also means one clock wide (R9).
  always @(negedge clk) begin
    if (rst_n) begin
      if (start_p) n_start++;
      if (abort_p) n_abort++;
    end
  end

  typedef struct packed {
    logic [7:0] low_len;
    logic       lead;
    logic [7:0] late;
    logic [7:0] grace;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{8'd3,  1'b0, 8'd0, 8'd0},
    '{8'd4,  1'b1, 8'd0, 8'd0},
    '{8'd10, 1'b1, 8'd0, 8'd0},
    '{8'd10, 1'b0, 8'd0, 8'd0},
    '{8'd10, 1'b0, 8'd3, 8'd0},
    '{8'd10, 1'b0, 8'd5, 8'd5},
    '{8'd10, 1'b0, 8'd6, 8'd5},
    '{8'd10, 1'b0, 8'd1, 8'd1},
    '{8'd10, 1'b0, 8'd2, 8'd1},
    '{8'd10, 1'b0, 8'd0, 8'd8},
    '{8'd2,  1'b1, 8'd0, 8'd3},
    '{8'd12, 1'b0, 8'd9, 8'd12}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic note_abort();
    if (exp_tally < TMAX) exp_tally++;
  endtask

  // 0 nothing, 1 start, 2 abort, derived from R2-R5.
  function automatic int exp_outcome(input vec_t v);
    if (int'(v.low_len) < FILT) return 0;
    if (v.lead) return 1;
    if (v.late != 0 && v.late <= v.grace) return 1;
    return 2;
  endfunction

  task automatic run_vec(input vec_t v);
    int s0, a0, ex;
    string tag;
    grace = v.grace; cmd_n = 1'b1; dir = 1'b1;
    cyc(4);
    s0 = n_start; a0 = n_abort;
    cmd_n = 1'b0;
    for (int i = 0; i < int'(v.low_len); i++) begin
      if (v.lead && i == int'(v.low_len) - 1) dir = 1'b0;
      @(negedge clk);
    end
    cmd_n = 1'b1;
    if (!v.lead && v.late != 0) begin
      cyc(int'(v.late));
      dir = 1'b0;
    end
    cyc(40);
    ex = exp_outcome(v);
    tag = (ex == 0) ? "R2 glitch" : (ex == 1) ? "R3/R5 accept" :
          (v.grace == 0) ? "R4 abort" : "R5 grace abort";
    chk({tag, " start count (R9)"}, n_start - s0, (ex == 1) ? 1 : 0);
    chk({tag, " abort count (R9)"}, n_abort - a0, (ex == 2) ? 1 : 0);
    chk({tag, " busy released"}, int'(busy_n), 1);
    if (ex == 2) note_abort();
    chk("R11 abort tally", int'(aborts), exp_tally);
    dir = 1'b1;
  endtask

  // Release with direction low at busy clock j (first busy-low clock is 1).
  task automatic coincide(input int j, input int want_start);
    int k, s0, a0;
    grace = '0; dir = 1'b1; cmd_n = 1'b1;
    cyc(4);
    cmd_n = 1'b0;
    k = 0;
    while (busy_n && k < 20) begin @(negedge clk); k++; end
    for (int i = 1; i < j; i++) @(negedge clk);
    s0 = n_start; a0 = n_abort;
    dir = 1'b0; cmd_n = 1'b1;
    cyc(6);
    chk("R7 same-cycle start count", n_start - s0, want_start);
    chk("R7 same-cycle abort count", n_abort - a0, 1 - want_start);
    chk("R7 busy released", int'(busy_n), 1);
    if (want_start == 0) note_abort();
    dir = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    int s0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 busy after reset", int'(busy_n), 1);
    chk("R1 start after reset", int'(start_p), 0);
    chk("R1 abort after reset", int'(abort_p), 0);
    chk("R1 state after reset", int'(st), 0);
    chk("R1 tally after reset", int'(aborts), 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R2 exact acknowledge latency, R10 codes, R3 start timing
    grace = '0; dir = 1'b1; cyc(4);
    cmd_n = 1'b0;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt++;
      if (!busy_n) break;
    end
    chk("R2 busy latency", cnt, FILT + 2);
    chk("R10 acknowledge code", int'(st), 1);
    cyc(1);
    chk("R10 wait code", int'(st), 2);
    dir = 1'b0; cyc(1);
    cmd_n = 1'b1;
    cyc(3);
    chk("R3 start pulse timing", int'(start_p), 1);
    chk("R3 busy with start", int'(busy_n), 1);
    chk("R10 idle code", int'(st), 0);
    cyc(1);
    chk("R9 start one wide", int'(start_p), 0);
    dir = 1'b1;

    // R5 grace state and exact expiry
    grace = 8'd5; cyc(4);
    cmd_n = 1'b0; cyc(10);
    cmd_n = 1'b1;
    cyc(3);
    chk("R5 grace code", int'(st), 3);
    chk("R5 busy in grace", int'(busy_n), 0);
    cyc(5);
    chk("R5 abort at grace end", int'(abort_p), 1);
    chk("R10 abort code", int'(st), 4);
    chk("R10 busy in abort", int'(busy_n), 1);
    note_abort();
    cyc(1);
    chk("R9 abort one wide", int'(abort_p), 0);

    // R6 watchdog bound, R8 no re-trigger while held
    grace = '0; cyc(4);
    cmd_n = 1'b0;
    cnt = 0;
    for (int i = 0; i < 20 && busy_n; i++) @(negedge clk);
    for (int i = 0; i < 2 * WDOG && !busy_n; i++) begin
      cnt++;
      @(negedge clk);
    end
    chk("R6 busy low length", cnt, WDOG);
    chk("R6 watchdog abort", int'(abort_p), 1);
    note_abort();
    s0 = n_start;
    cyc(20);
    chk("R8 held strobe ignored busy", int'(busy_n), 1);
    chk("R8 held strobe ignored state", int'(st), 0);
    chk("R8 no start while held", n_start - s0, 0);
    cmd_n = 1'b1; cyc(3);
    cmd_n = 1'b0; cyc(FILT + 2);
    chk("R8 re-armed after release", int'(busy_n), 0);
    dir = 1'b0; cmd_n = 1'b1; cyc(6); dir = 1'b1;
    chk("R11 tally after watchdog", int'(aborts), exp_tally);

    // R7 acceptance versus watchdog in the same cycle
    coincide(WDOG - 3, 1);
    coincide(WDOG - 2, 0);
    chk("R11 tally after coincidence", int'(aborts), exp_tally);

    // R11 saturation
    for (int i = 0; i < TMAX + 2; i++) begin
      grace = '0; cyc(3);
      cmd_n = 1'b0; cyc(8);
      cmd_n = 1'b1; cyc(6);
      note_abort();
    end
    chk("R11 tally saturates", int'(aborts), TMAX);
    chk("R11 expected saturation", exp_tally, TMAX);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule